// File: doc/BRIEF.md
# Per-Bit Write Centering Trainer

This block tunes the write-data delay of each data line in one byte lane. The goal is for written data to be sampled in the middle of its valid window. For one bit at a time, it sets a delay tap and writes a short known burst. It then reads the same location back and checks only the line under training. After that it moves the tap by one step and repeats. It sweeps every tap value for that bit, then moves on to the next bit.

For each bit, the first passing tap becomes the left edge. The last tap of that first unbroken run of passes becomes the right edge. The block programs the midpoint of the two edges as the bit's result. A bit that never passes is marked as failed and gets tap 0. Training then continues with the next bit.

Traffic goes out on a valid/ready request channel. The requester holds `req_valid` and the whole payload steady until `req_ready` is seen high at a clock edge. The memory side may insert any number of stall cycles. Read data comes back on a valid/ready response channel. `rsp_ready` is raised only while the block is waiting for the beats of an accepted read. The memory may present `rsp_valid` early, and a beat counts only on a cycle where both `rsp_valid` and `rsp_ready` are high.

Top module: `wct_trainer`

## Requirements
- R1: While reset is held, and after it is released with no start, busy, done, req_valid, rsp_ready, fail_vec and tap_final are all zero.
- R2: At each tap the block sends a write burst of BEATS beats. Beat k carries 0x55 (bit i set when i is even) when k is even and 0xAA when k is odd, and req_last is high only on beat BEATS-1. Then comes exactly one read request (req_wr low, req_last high).
- R3: While req_valid is high and req_ready is low, req_valid, req_wr, req_data and req_last stay unchanged. rsp_ready is high only after a read has been accepted and until BEATS response beats have been taken, and never while req_valid is high.
- R4: Bits are trained in the order 0 to NBITS-1. For each bit, taps go from 0 to 2^TAPW-1 in steps of one. dly_sel and dly_tap stay constant from the first write beat of a tap until its last response beat.
- R5: A tap passes only when all BEATS read beats match the written beats on bit dly_sel. Mismatches on the other bits have no effect.
- R6: The left edge is the first passing tap. The right edge is the last passing tap of the first unbroken run of passes. Passes after the first failing tap that follows that run are ignored.
- R7: A bit that passes at some tap gets tap_final[b*TAPW +: TAPW] = (left + right) >> 1, and its fail_vec bit is 0.
- R8: A bit with no passing tap gets fail_vec[b] = 1 and a tap_final field of 0, and the sweep continues with the next bit.
- R9: done rises only after all NBITS bits are finished, with busy low. Results and done hold until the next start. A start while busy is ignored, and a start at idle clears done, fail_vec and tap_final.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a training run (used only when idle) |
| busy | output | 1 | Training in progress |
| done | output | 1 | All bits trained; results valid |
| req_valid | output | 1 | Traffic request valid |
| req_ready | input | 1 | Traffic request accepted |
| req_wr | output | 1 | 1 = write beat, 0 = read request |
| req_data | output | NBITS | Write beat data |
| req_last | output | 1 | Final beat of a write burst, or a read request |
| rsp_valid | input | 1 | Read beat valid |
| rsp_ready | output | 1 | Trainer can take a read beat |
| rsp_data | input | NBITS | Read beat data |
| dly_sel | output | log2(NBITS) | Data line whose write delay is being driven |
| dly_tap | output | TAPW | Write delay tap for dly_sel |
| tap_final | output | NBITS*TAPW | Trained tap per bit, bit b at [b*TAPW +: TAPW] |
| fail_vec | output | NBITS | Per-bit training failure flags |

## Verification
The hardest case to reach from the ports is a pass window that closes and then opens again later in the same sweep. The second run must leave the right edge untouched. A related hard case is a single bad beat inside an otherwise clean burst, which must still fail the tap. To reach these, the behavioural memory in the bench holds a per-bit, per-tap pass mask. It corrupts only one beat of the line under training when a tap fails. It also always inverts every other line, so any leak from the unselected bits would show up. The bench sweeps many mask shapes: empty masks, single-tap windows at both ends, full windows and two-run windows. Random-looking request and response stalls are switched on for half of the runs.

// File: rtl/wct_pkg.sv
`timescale 1ns/1ps
package wct_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_RX,
    ST_EVAL,
    ST_FIN
  } wct_state_e;
endpackage

// File: rtl/wct_pattern.sv
`timescale 1ns/1ps
// Alternating training word: even beats set the even lines, odd beats the odd lines.
module wct_pattern #(
  parameter int LANE_W = 8,
  parameter int BEAT_W = 3
) (
  input  logic [BEAT_W-1:0] beat,
  output logic [LANE_W-1:0] data
);
  for (genvar i = 0; i < LANE_W; i++) begin : g_line
    localparam logic EVEN_LINE = ((i % 2) == 0);
    assign data[i] = beat[0] ^ EVEN_LINE;
  end
endmodule

// File: rtl/wct_bitcheck.sv
`timescale 1ns/1ps
// Sticky mismatch flag on the selected data line across one read burst.
module wct_bitcheck #(
  parameter int LANE_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              beat_fire,
  input  logic [LANE_W-1:0] got,
  input  logic [LANE_W-1:0] want,
  input  logic [SEL_W-1:0]  sel,
  output logic              miss
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                miss <= 1'b0;
    else if (clr)                              miss <= 1'b0;
    else if (beat_fire && (got[sel] != want[sel])) miss <= 1'b1;
  end

  // R5
  miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss && !clr |=> miss);
endmodule

// File: rtl/wct_window.sv
`timescale 1ns/1ps
// Tracks left edge and end of the first contiguous pass run; gives the midpoint.
module wct_window #(
  parameter int TAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             pass,
  input  logic [TAP_W-1:0] tap,
  output logic             found,
  output logic [TAP_W-1:0] centre
);
  logic             closed;
  logic [TAP_W-1:0] left_q, right_q;
  logic [TAP_W:0]   sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found <= 1'b0; closed <= 1'b0; left_q <= '0; right_q <= '0;
    end else if (clr) begin
      found <= 1'b0; closed <= 1'b0; left_q <= '0; right_q <= '0;
    end else if (upd) begin
      if (pass && !found) begin
        found   <= 1'b1;
        left_q  <= tap;
        right_q <= tap;
      end else if (pass && !closed) begin
        right_q <= tap;
      end else if (!pass && found) begin
        closed <= 1'b1;
      end
    end
  end

  assign sum    = {1'b0, left_q} + {1'b0, right_q};
  assign centre = sum[TAP_W:1];

  // R6
  left_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found && $past(found) && !$past(clr) |-> $stable(left_q));
  // R6
  right_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> right_q >= left_q);
  // R6
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    closed && !clr |=> $stable(right_q));
endmodule

// File: rtl/wct_trainer.sv
`timescale 1ns/1ps
module wct_trainer
  import wct_pkg::*;
#(
  parameter int NBITS = 8,
  parameter int TAPW  = 8,
  parameter int BEATS = 8,
  localparam int SELW = $clog2(NBITS),
  localparam int BW   = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_wr,
  output logic [NBITS-1:0]  req_data,
  output logic              req_last,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [NBITS-1:0]  rsp_data,
  output logic [SELW-1:0]   dly_sel,
  output logic [TAPW-1:0]   dly_tap,
  output logic [NBITS*TAPW-1:0] tap_final,
  output logic [NBITS-1:0]  fail_vec
);
  wct_state_e            state;
  logic [SELW-1:0]       bit_q;
  logic [TAPW-1:0]       tap_q;
  logic [BW-1:0]         beat_q;
  logic [NBITS*TAPW-1:0] res_q;
  logic [NBITS-1:0]      fail_q;
  logic                  done_q;
  logic [NBITS-1:0]      pat;
  logic                  miss, found;
  logic [TAPW-1:0]       centre;
  logic                  kick, last_beat, last_tap, last_bit;

  assign kick      = (state == ST_IDLE) && start;
  assign last_beat = (beat_q == BW'(BEATS - 1));
  assign last_tap  = (tap_q == '1);
  assign last_bit  = (bit_q == SELW'(NBITS - 1));

  wct_pattern #(.LANE_W(NBITS), .BEAT_W(BW)) u_pat (
    .beat (beat_q),
    .data (pat)
  );

  wct_bitcheck #(.LANE_W(NBITS), .SEL_W(SELW)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (kick || (state == ST_EVAL)),
    .beat_fire (rsp_valid && rsp_ready),
    .got       (rsp_data),
    .want      (pat),
    .sel       (bit_q),
    .miss      (miss)
  );

  wct_window #(.TAP_W(TAPW)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (kick || (state == ST_FIN)),
    .upd    (state == ST_EVAL),
    .pass   (!miss),
    .tap    (tap_q),
    .found  (found),
    .centre (centre)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bit_q  <= '0;
      tap_q  <= '0;
      beat_q <= '0;
      res_q  <= '0;
      fail_q <= '0;
      done_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_WR;
          bit_q  <= '0;
          tap_q  <= '0;
          beat_q <= '0;
          res_q  <= '0;
          fail_q <= '0;
          done_q <= 1'b0;
        end
        ST_WR: if (req_ready) begin
          if (last_beat) begin
            beat_q <= '0;
            state  <= ST_RD;
          end else begin
            beat_q <= beat_q + BW'(1);
          end
        end
        ST_RD: if (req_ready) state <= ST_RX;
        ST_RX: if (rsp_valid) begin
          if (last_beat) begin
            beat_q <= '0;
            state  <= ST_EVAL;
          end else begin
            beat_q <= beat_q + BW'(1);
          end
        end
        ST_EVAL: begin
          if (last_tap) state <= ST_FIN;
          else begin
            tap_q <= tap_q + TAPW'(1);
            state <= ST_WR;
          end
        end
        ST_FIN: begin
          res_q[bit_q*TAPW +: TAPW] <= found ? centre : '0;
          fail_q[bit_q]             <= !found;
          tap_q                     <= '0;
          if (last_bit) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + SELW'(1);
            state <= ST_WR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign req_valid = (state == ST_WR) || (state == ST_RD);
  assign req_wr    = (state == ST_WR);
  assign req_data  = (state == ST_WR) ? pat : '0;
  assign req_last  = ((state == ST_WR) && last_beat) || (state == ST_RD);
  assign rsp_ready = (state == ST_RX);
  assign dly_sel   = bit_q;
  assign dly_tap   = tap_q;
  assign tap_final = res_q;
  assign fail_vec  = fail_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_wr) && $stable(req_data) && $stable(req_last));
  // R3
  rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !req_valid);
  // R4
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |-> $stable(dly_tap) && $stable(dly_sel));
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  for (genvar i = 0; i < NBITS; i++) begin : g_failchk
    // R8
    fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_vec[i] |-> (tap_final[i*TAPW +: TAPW] == '0));
  end
endmodule

// File: tb/wct_trainer_tb_top.sv
`timescale 1ns/1ps
module wct_trainer_tb_top;
  localparam int NB = 8;
  localparam int TW = 5;
  localparam int BE = 8;
  localparam int NT = 1 << TW;
  localparam int SW = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #2.5 clk = ~clk;

  logic busy, done, req_valid, req_ready, req_wr, req_last, rsp_valid, rsp_ready;
  logic [NB-1:0] req_data, rsp_data, fail_vec;
  logic [SW-1:0] dly_sel;
  logic [TW-1:0] dly_tap;
  logic [NB*TW-1:0] tap_final;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_en = 1'b0;
  logic [NT-1:0] mask [NB];

  int wr_idx, rd_idx, exp_bit, exp_tap;
  bit rd_active, rsp_pend;
  logic [TW-1:0] cur_tap;
  logic [NB-1:0] wbuf [BE];
  logic [NB-1:0] rbuf [BE];

  wct_trainer #(.NBITS(NB), .TAPW(TW), .BEATS(BE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_data(req_data), .req_last(req_last), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .dly_sel(dly_sel),
    .dly_tap(dly_tap), .tap_final(tap_final), .fail_vec(fail_vec)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] pat(input int k);
    logic [NB-1:0] d;
    for (int i = 0; i < NB; i++) d[i] = ((i % 2) == 0) ^ (k % 2 == 1);
    return d;
  endfunction

  function automatic logic [NT-1:0] span(input int lo, input int hi);
    logic [NT-1:0] m = '0;
    for (int i = 0; i < NT; i++) if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  // Behavioural memory: decisions made at the falling edge for the next rising edge.
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
      wr_idx = 0; rd_idx = 0; rd_active = 0; rsp_pend = 0;
    end else begin
      if (rsp_pend) begin
        rd_idx++;
        if (rd_idx == BE) rd_active = 0;
      end
      req_ready = bp_en ? ((cyc % 7) != 2 && (cyc % 11) != 5) : 1'b1;
      if (req_valid && req_ready) begin
        if (req_wr) begin
          if (wr_idx == 0) begin
            chk(dly_sel == exp_bit && dly_tap == exp_tap, "R4 sweep order",
                dly_sel * NT + dly_tap, exp_bit * NT + exp_tap);
            cur_tap = dly_tap;
          end
          chk(req_data == pat(wr_idx) && req_last == (wr_idx == BE - 1), "R2 write beat",
              {req_last, req_data}, {(wr_idx == BE - 1), pat(wr_idx)});
          if (wr_idx < BE) wbuf[wr_idx] = req_data;
          wr_idx++;
        end else begin
          chk(wr_idx == BE && req_last && !rd_active, "R2 read after burst", wr_idx, BE);
          wr_idx = 0;
          for (int k = 0; k < BE; k++) rbuf[k] = wbuf[k] ^ ~(NB'(1) << dly_sel);
          if (!mask[dly_sel][dly_tap]) rbuf[dly_tap % BE][dly_sel] = ~rbuf[dly_tap % BE][dly_sel];
          rd_active = 1; rd_idx = 0;
          exp_tap++;
          if (exp_tap == NT) begin exp_tap = 0; exp_bit++; end
        end
      end
      if (rsp_ready) chk(rd_active, "R3 rsp_ready only after read", rsp_ready, rd_active);
      if (rd_active && (!bp_en || (cyc % 3) != 1)) begin
        rsp_valid = 1'b1; rsp_data = rbuf[rd_idx];
      end else begin
        rsp_valid = 1'b0; rsp_data = '0;
      end
      rsp_pend = rsp_valid && rsp_ready;
      if (rsp_pend) chk(dly_tap == cur_tap, "R4 tap held during read", dly_tap, cur_tap);
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(input bit poke);
    exp_bit = 0; exp_tap = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !done && fail_vec == '0 && tap_final == '0, "R9 start clears and runs",
        {busy, done, fail_vec}, {1'b1, 1'b0, NB'(0)});
    if (poke) begin
      repeat (400) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy && dly_sel == 0 && dly_tap > 5, "R9 start ignored while busy", dly_tap, 6);
    end
    while (!done) @(negedge clk);
    chk(!busy && exp_bit == NB, "R9 done after all bits", exp_bit, NB);
    for (int b = 0; b < NB; b++) begin
      int l = -1, r = -1, et;
      bit closed = 0, ef;
      for (int i = 0; i < NT; i++) begin
        if (mask[b][i]) begin
          if (l < 0) begin l = i; r = i; end
          else if (!closed) r = i;
        end else if (l >= 0) closed = 1;
      end
      ef = (l < 0);
      et = ef ? 0 : (l + r) / 2;
      if (ef) chk(fail_vec[b] && tap_final[b*TW +: TW] == 0, "R8 failed bit",
                  {fail_vec[b], tap_final[b*TW +: TW]}, {1'b1, TW'(0)});
      else chk(!fail_vec[b] && tap_final[b*TW +: TW] == et, "R7/R6 centre tap",
               {fail_vec[b], tap_final[b*TW +: TW]}, {1'b0, TW'(et)});
    end
    begin
      logic [NB*TW-1:0] t0 = tap_final;
      logic [NB-1:0] f0 = fail_vec;
      repeat (6) @(negedge clk);
      chk(done && !busy && tap_final == t0 && fail_vec == f0, "R9 results hold", tap_final, t0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req_valid && !rsp_ready && fail_vec == '0 && tap_final == '0,
        "R1 reset state", {busy, done, req_valid, rsp_ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req_valid && !rsp_ready && fail_vec == '0 && tap_final == '0,
        "R1 idle after reset", {busy, done, req_valid, rsp_ready}, 0);

    mask[0] = span(3, 10);
    mask[1] = span(0, NT - 1);
    mask[2] = '0;
    mask[3] = span(NT - 1, NT - 1);
    mask[4] = span(2, 5) | span(20, 25);
    mask[5] = span(0, 0);
    mask[6] = span(10, 11);
    mask[7] = span(17, 28);
    bp_en = 1'b0;
    run(1'b0);

    bp_en = 1'b1;
    run(1'b1);

    for (int k = 1; k <= 6; k++) begin
      for (int b = 0; b < NB; b++) begin
        int lo = (k * 7 + b * 5) % NT;
        int len = (k * 3 + b) % 9;
        int hi = (lo + len > NT - 1) ? NT - 1 : lo + len;
        mask[b] = span(lo, hi);
        if ((k + b) % 4 == 1 && hi + 3 < NT) mask[b] = mask[b] | span(hi + 3, hi + 4);
        if ((k + b) % 5 == 0) mask[b] = '0;
      end
      bp_en = (k % 2) == 1;
      run(1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule